// File: doc/BRIEF.md
# Sliding-window fast over-current detector

This block watches the raw one-bit stream of a sigma-delta modulator and flags an over-current long before a decimated sample could. Every modulator clock (given as a clock enable) it takes one data bit, keeps a running count of the zeros among the most recent N bits, and compares that count against an upper and a lower zero-count limit. A count above the upper limit or below the lower limit is an error. The error latches a trip status bit, which drives the trip output high, and also latches the limit that caused it.

The window length N is programmable. After the block is enabled, or after the window length changes, comparisons are suppressed until 32 modulator bits have been taken in, so the window is full of real data before it is judged. The trip status and its cause bits remain set until a clear pulse removes them, so control software can read the cause before it re-arms the trip.

Top module: `sdm_fast_ocd`

## Requirements
- R1: A window length below 4 acts as 4 and a length above 32 acts as 32; `win_len` is an unsigned 6-bit value.
- R2: The zero count covers the last N bits taken while `mod_ce` was high; bits presented while `mod_ce` is low have no effect.
- R3: An upper error occurs when the zero count is strictly greater than `zero_max`, and a lower error when it is strictly less than `zero_min`; a count equal to a limit raises no error.
- R4: No error is raised until 32 bits have been taken in since the block was enabled or last restarted.
- R5: An error sets `trip_status` and `trip_out` at the next clock edge, and sets `cause_high` for an upper error or `cause_low` for a lower error; all three remain set afterward.
- R6: A `trip_clr` pulse clears `trip_status`, `trip_out`, `cause_high` and `cause_low`, unless an error is present in the same cycle, in which case the error takes priority.
- R7: Driving `enable` low, or changing the effective window length, empties the window and restarts the 32-bit warm-up; neither action clears a latched trip or its causes.
- R8: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Detector enable; low holds it in restart |
| mod_ce | input | 1 | One-cycle pulse per modulator clock |
| mod_bit | input | 1 | Modulator data bit, taken when `mod_ce` is high |
| win_len | input | 6 | Window length in bits (effective 4 to 32) |
| zero_max | input | 6 | Upper zero-count limit |
| zero_min | input | 6 | Lower zero-count limit |
| trip_clr | input | 1 | Clears trip status and cause bits |
| cause_high | output | 1 | Sticky: count exceeded `zero_max` |
| cause_low | output | 1 | Sticky: count fell below `zero_min` |
| trip_status | output | 1 | Sticky trip status bit |
| trip_out | output | 1 | Trip output pin level |

## Verification
The bench builds the block with its default parameters: a history of 32 bits, a minimum window of 4, and a warm-up of 32 bits. These parameters make the full window, the shortest window, and both clamp edges reachable with streams of only about 40 bits. Because the warm-up is as long as the largest window, every table vector is judged on a fully filled window. The count for each vector can therefore be worked out by hand from a periodic pattern, including counts that land exactly on a limit.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

  // Clamp a requested window length into the legal range.
  function automatic int clamp_len(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Next zero count: add the arriving bit if it is zero, drop the departing bit if it was zero.
  function automatic int zero_step(input int cnt, input logic arriving, input logic departing);
    int n;
    n = cnt;
    if (!arriving)  n = n + 1;
    if (!departing) n = n - 1;
    return n;
  endfunction

  // Limit test: over the top or under the bottom.
  function automatic logic above(input int cnt, input int lim);
    return cnt > lim;
  endfunction

  function automatic logic below(input int cnt, input int lim);
    return cnt < lim;
  endfunction

endpackage

// File: rtl/ocd_window.sv
module ocd_window #(
  parameter int MAX_WIN = 32,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             din,
  input  logic             restart,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] zcnt
);
  import ocd_pkg::*;

  logic [MAX_WIN-1:0] hist;
  logic [MAX_WIN-1:0] taps;
  logic               departing;

  // One tap per history position; only the one at the window edge is live.
  for (genvar k = 0; k < MAX_WIN; k++) begin : g_tap
    assign taps[k] = (len == LEN_W'(k + 1)) & hist[k];
  end
  // An empty-window default of ones means a missing tap counts as "not a zero".
  assign departing = |taps | (len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '1;
      zcnt <= '0;
    end else if (restart) begin
      hist <= '1;
      zcnt <= '0;
    end else if (ce) begin
      hist <= {hist[MAX_WIN-2:0], din};
      zcnt <= CNT_W'(zero_step(int'(zcnt), din, departing));
    end
  end

endmodule

// File: rtl/ocd_warmup.sv
module ocd_warmup #(
  parameter int WARMUP = 32,
  parameter int WARM_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic restart,
  output logic armed
);
  logic [WARM_W-1:0] cnt;

  assign armed = (cnt == WARM_W'(WARMUP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (ce && !armed) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ocd_trip.sv
module ocd_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic err_hi,
  input  logic err_lo,
  input  logic clr,
  output logic cause_hi,
  output logic cause_lo,
  output logic trip_sts
);
  logic err_any;
  assign err_any = err_hi | err_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_hi <= 1'b0;
      cause_lo <= 1'b0;
      trip_sts <= 1'b0;
    end else if (err_any) begin
      cause_hi <= cause_hi | err_hi;
      cause_lo <= cause_lo | err_lo;
      trip_sts <= 1'b1;
    end else if (clr) begin
      cause_hi <= 1'b0;
      cause_lo <= 1'b0;
      trip_sts <= 1'b0;
    end
  end

endmodule

// File: rtl/sdm_fast_ocd.sv
module sdm_fast_ocd #(
  parameter int MIN_WIN = 4,
  parameter int MAX_WIN = 32,
  parameter int WARMUP  = 32,
  localparam int LEN_W  = $clog2(MAX_WIN + 1),
  localparam int CNT_W  = $clog2(MAX_WIN + 1),
  localparam int WARM_W = $clog2(WARMUP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mod_ce,
  input  logic             mod_bit,
  input  logic [LEN_W-1:0] win_len,
  input  logic [CNT_W-1:0] zero_max,
  input  logic [CNT_W-1:0] zero_min,
  input  logic             trip_clr,
  output logic             cause_high,
  output logic             cause_low,
  output logic             trip_status,
  output logic             trip_out
);
  import ocd_pkg::*;

  // Named internal events, brought out for the checker.
  logic [LEN_W-1:0] len_c;
  logic [LEN_W-1:0] len_q;
  logic             restart;
  logic             armed;
  logic [CNT_W-1:0] zcnt;
  logic             err_hi;
  logic             err_lo;

  assign len_c   = LEN_W'(clamp_len(int'(win_len), MIN_WIN, MAX_WIN));
  assign restart = !enable || (len_c != len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= LEN_W'(MIN_WIN);
    else        len_q <= len_c;
  end

  ocd_window #(.MAX_WIN(MAX_WIN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .ce(mod_ce), .din(mod_bit),
    .restart(restart), .len(len_q), .zcnt(zcnt)
  );

  ocd_warmup #(.WARMUP(WARMUP), .WARM_W(WARM_W)) u_warm (
    .clk(clk), .rst_n(rst_n), .ce(mod_ce), .restart(restart), .armed(armed)
  );

  assign err_hi = armed && !restart && above(int'(zcnt), int'(zero_max));
  assign err_lo = armed && !restart && below(int'(zcnt), int'(zero_min));

  ocd_trip u_trip (
    .clk(clk), .rst_n(rst_n), .err_hi(err_hi), .err_lo(err_lo), .clr(trip_clr),
    .cause_hi(cause_high), .cause_lo(cause_low), .trip_sts(trip_status)
  );

  assign trip_out = trip_status;

endmodule

// File: rtl/ocd_checker.sv
module ocd_checker #(
  parameter int LEN_W = 6,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             armed,
  input logic             err_hi,
  input logic             err_lo,
  input logic             clr,
  input logic [CNT_W-1:0] zcnt,
  input logic [LEN_W-1:0] len_q,
  input logic             cause_hi,
  input logic             cause_lo,
  input logic             trip_sts
);
  // R2: the count never exceeds the active window length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zcnt) <= int'(len_q));

  // R3: an upper error latches its own cause bit
  a_r3_high_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_hi |=> cause_hi);

  // R4 and R7: a restart disarms the comparison and empties the window
  a_r4_restart_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!armed && zcnt == '0));

  // R5: any error trips at the next edge
  a_r5_error_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hi || err_lo) |=> trip_sts);

  // R5: the trip stays latched without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_sts && !clr) |=> trip_sts);

  // R6: a clear with no error empties status and causes
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_hi && !err_lo) |=> (!trip_sts && !cause_hi && !cause_lo));
endmodule

bind sdm_fast_ocd ocd_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .armed(armed),
  .err_hi(err_hi), .err_lo(err_lo), .clr(trip_clr), .zcnt(zcnt), .len_q(len_q),
  .cause_hi(cause_high), .cause_lo(cause_low), .trip_sts(trip_status)
);

// File: tb/tb_sdm_fast_ocd.sv
module tb_sdm_fast_ocd;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       mod_ce = 1'b0;
  logic       mod_bit = 1'b1;
  logic [5:0] win_len = 6'd8;
  logic [5:0] zero_max = 6'd32;
  logic [5:0] zero_min = 6'd0;
  logic       trip_clr = 1'b0;
  logic       cause_high, cause_low, trip_status, trip_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdm_fast_ocd dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mod_ce(mod_ce), .mod_bit(mod_bit),
    .win_len(win_len), .zero_max(zero_max), .zero_min(zero_min), .trip_clr(trip_clr),
    .cause_high(cause_high), .cause_low(cause_low), .trip_status(trip_status),
    .trip_out(trip_out)
  );

  // Vector: len, zmax, zmin, pattern, expected high cause, expected low cause.
  // Pattern 0 all ones, 1 all zeros, 2 alternating, 3 one zero in every four.
  typedef struct packed {
    logic [5:0] len; logic [5:0] zmax; logic [5:0] zmin;
    logic [1:0] pat; logic hi; logic lo;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{6'd8,  6'd6,  6'd2,  2'd2, 1'b0, 1'b0},  // R3 4 zeros inside limits
    '{6'd16, 6'd12, 6'd2,  2'd1, 1'b1, 1'b0},  // R3 16 > 12
    '{6'd32, 6'd30, 6'd4,  2'd0, 1'b0, 1'b1},  // R3 0 < 4
    '{6'd4,  6'd1,  6'd0,  2'd3, 1'b0, 1'b0},  // R3 equal to max
    '{6'd4,  6'd0,  6'd0,  2'd3, 1'b1, 1'b0},  // R3 1 > 0
    '{6'd32, 6'd8,  6'd8,  2'd3, 1'b0, 1'b0},  // R3 equal to both
    '{6'd20, 6'd20, 6'd11, 2'd2, 1'b0, 1'b1},  // R3 10 < 11
    '{6'd2,  6'd32, 6'd3,  2'd1, 1'b0, 1'b0},  // R1 len 2 acts as 4: 4 zeros
    '{6'd63, 6'd31, 6'd0,  2'd1, 1'b1, 1'b0}   // R1 len 63 acts as 32: 32 > 31
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_bit(input logic b);
    mod_bit = b; mod_ce = 1'b1; tick();
    mod_ce = 1'b0; tick();
  endtask

  task automatic send_pat(input logic [1:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      case (pat)
        2'd0: send_bit(1'b1);
        2'd1: send_bit(1'b0);
        2'd2: send_bit(logic'(i % 2));
        default: send_bit((i % 4) != 0);
      endcase
    end
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic clear_trip();
    trip_clr = 1'b1; tick(); trip_clr = 1'b0; tick();
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    // R8: reset state
    check("R8", "trip_out in reset", trip_out, 1'b0);
    check("R8", "cause_high in reset", cause_high, 1'b0);
    check("R8", "cause_low in reset", cause_low, 1'b0);
    rst_n = 1'b1; tick();
    check("R8", "trip_status after reset", trip_status, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      enable = 1'b0;
      win_len = VECS[v].len; zero_max = VECS[v].zmax; zero_min = VECS[v].zmin;
      tick(); clear_trip();
      enable = 1'b1; tick();
      send_pat(VECS[v].pat, 40);
      check(v < 7 ? "R3" : "R1", $sformatf("vec %0d cause_high", v), cause_high, VECS[v].hi);
      check(v < 7 ? "R3" : "R1", $sformatf("vec %0d cause_low", v), cause_low, VECS[v].lo);
      check("R5", $sformatf("vec %0d trip_out", v), trip_out, VECS[v].hi | VECS[v].lo);
    end

    // R4: warm-up of 32 bits with a window of 8 zeros over a limit of 7
    enable = 1'b0; win_len = 6'd8; zero_max = 6'd7; zero_min = 6'd0;
    tick(); clear_trip(); enable = 1'b1; tick();
    send_pat(2'd1, 31);
    check("R4", "no trip after 31 bits", trip_out, 1'b0);
    // R2: idle cycles with a zero on the data line and no enable pulse count nothing
    mod_bit = 1'b0;
    for (int i = 0; i < 10; i++) tick();
    check("R2", "no trip while mod_ce idle", trip_out, 1'b0);
    send_bit(1'b0);
    check("R4", "trip on 32nd bit", trip_out, 1'b1);
    check("R5", "high cause latched", cause_high, 1'b1);

    // R6: clear is overridden by a live error
    clear_trip();
    check("R6", "error beats clear", trip_status, 1'b1);
    // R7: disabling keeps the latched trip
    enable = 1'b0; tick(); tick();
    check("R7", "disable keeps trip", trip_out, 1'b1);
    check("R7", "disable keeps cause", cause_high, 1'b1);
    clear_trip();
    check("R6", "clear drops trip", trip_out, 1'b0);
    check("R6", "clear drops cause", cause_high, 1'b0);

    // R7: a length change restarts the warm-up
    enable = 1'b1; win_len = 6'd8; tick();
    send_pat(2'd1, 24);
    win_len = 6'd9; tick();
    send_pat(2'd1, 20);
    check("R7", "no trip 20 bits after length change", trip_out, 1'b0);
    send_pat(2'd1, 12);
    check("R7", "trip 32 bits after length change", trip_out, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule